// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the slave side of a small serial EEPROM with a 128 x 8 byte array. A host talks to it over a chip select, a serial clock and a data input. The block answers on a data output that has a separate drive enable, so the data output can be released to high impedance. The three serial inputs are resynchronised into the system clock domain. Serial clock rising edges are found by edge detection. All command timing is counted in those detected edges.

A command starts with a start bit, which is the first 1 sampled on the data input while chip select is high. Two opcode bits follow, then seven address bits. Write-type commands then take eight data bits. The supported commands are:

- byte read
- byte write
- byte erase
- erase of the whole array
- write of one byte to every location
- write enable and write disable, which set or clear a protection latch

Every command that changes the array starts a self-timed program cycle of `PROG_CYCLES` system clocks. This cycle keeps running when chip select drops. The host can then poll ready/busy on the data output.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the data output is not driven. Whenever chip select is low the command logic returns to idle and the output drive is released, so a command cut short by chip select going low has no effect.
- R2: With chip select high, serial clock edges that sample a 0 before any 1 leave the block idle. The first 1 sampled is taken as the start bit.
- R3: Opcode 10 is a read. The data output stays undriven while the header is clocked in (start bit, opcode, seven address bits, MSB first). From the 11th rising edge onward it drives the addressed byte MSB first, one bit per edge, for 18 edges in total.
- R4: Opcode 01 is a byte write. It takes 8 data bits, MSB first, after the address. The byte is stored at the end of the program cycle.
- R5: A write-enable latch is cleared by reset. Opcode 00 with address bits [6:5] = 11 sets it, and opcode 00 with [6:5] = 00 clears it. While it is clear, write, erase, erase-all and write-all start no program cycle and leave the array unchanged.
- R6: Opcode 11 is a byte erase. It uses 10 edges and sets the addressed byte to 0xFF.
- R7: Opcode 00 with address bits [6:5] = 10 erases every byte to 0xFF. Opcode 00 with [6:5] = 01 takes 8 data bits and writes that byte to every location.
- R8: Once a command has received all its edges, further serial clock edges and data input values are ignored until chip select has gone low and high again.
- R9: The program cycle lasts exactly `PROG_CYCLES` system clocks and needs no serial clock. If chip select rises after a low period while it runs, the data output drives 0 while busy and 1 once ready.
- R10: If chip select stays low for the whole program cycle, raising it afterwards leaves the output undriven. Write enable and write disable never produce status.
- R11: A start bit sampled while a program cycle runs is ignored, so no command can be accepted until the cycle ends.
- R12: The array contents are all 0xFF after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data / ready-busy level |
| dout_en_o | output | 1 | Drive enable for dout_o; low means high impedance |

## Verification
The checker watches several rules on every cycle:
- the output drive drops after chip select falls;
- a program cycle never starts while one is running or while the enable latch is clear;
- each busy period lasts exactly the configured number of clocks;
- the array is written only in the last busy cycle.

Some behaviour can only be shown by the bench's serial scenarios:
- the bit order of reads;
- the opcode and address-field decode;
- rejection of commands when writes are protected;
- that surplus edges are ignored;
- the difference between polling status during the cycle and raising chip select only after it ends.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } cmd_state_e;

    // primary opcodes
    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // sub-codes carried in the top two address bits when opcode is OPC_EXT
    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
    localparam logic [1:0] EXT_WEN   = 2'b11;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic din_i,
    output logic cs_s,
    output logic din_s,
    output logic sck_rise,
    output logic cs_rise
);

    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] din;
        logic              sck_prev;
        logic              cs_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.cs       = {q.cs[STAGES-2:0], cs_i};
        d.sck      = {q.sck[STAGES-2:0], sck_i};
        d.din      = {q.din[STAGES-2:0], din_i};
        d.sck_prev = q.sck[STAGES-1];
        d.cs_prev  = q.cs[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_s     = q.cs[STAGES-1];
    assign din_s    = q.din[STAGES-1];
    assign sck_rise = q.sck[STAGES-1] & ~q.sck_prev;
    assign cs_rise  = q.cs[STAGES-1] & ~q.cs_prev;

endmodule

// File: rtl/eep_cmd.sv
module eep_cmd
    import eep_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              din_s,
    input  logic              sck_rise,
    input  logic              cs_rise,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              prog_all,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              wen_o,
    output logic              dout_o,
    output logic              dout_en_o
);

    localparam int HDR_W   = 2 + ADDR_W;
    localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    typedef struct packed {
        cmd_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] rsh;
        logic              rd_bit;
        logic              rd_en;
        logic              st_show;
        logic              wen;
        logic              start;
        logic              all;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } cmd_t;

    cmd_t q, d;

    logic [HDR_W-1:0]  hdr_nx;
    logic [DATA_W-1:0] dat_nx;
    logic [1:0]        op_nx;
    logic [1:0]        ext_nx;

    assign hdr_nx  = {q.hdr[HDR_W-2:0], din_s};
    assign dat_nx  = {q.dat[DATA_W-2:0], din_s};
    assign op_nx   = hdr_nx[HDR_W-1 -: 2];
    assign ext_nx  = hdr_nx[ADDR_W-1 -: 2];
    assign rd_addr = hdr_nx[ADDR_W-1:0];

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (!cs_s) begin
            d.state   = ST_IDLE;
            d.cnt     = '0;
            d.rd_en   = 1'b0;
            d.st_show = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (cs_rise && prog_busy) d.st_show = 1'b1;
                    if (sck_rise && din_s && !prog_busy) begin
                        d.state   = ST_HDR;
                        d.cnt     = '0;
                        d.st_show = 1'b0;
                    end
                end
                ST_HDR: begin
                    if (sck_rise) begin
                        d.hdr = hdr_nx;
                        if (q.cnt == CNT_W'(HDR_W - 1)) begin
                            d.cnt   = '0;
                            d.state = ST_DONE;
                            unique case (op_nx)
                                OPC_READ: begin
                                    d.state = ST_READ;
                                    d.rsh   = rd_data;
                                end
                                OPC_WRITE: d.state = ST_DATA;
                                OPC_ERASE: begin
                                    if (q.wen) begin
                                        d.start = 1'b1;
                                        d.all   = 1'b0;
                                        d.paddr = hdr_nx[ADDR_W-1:0];
                                        d.pdata = '1;
                                    end
                                end
                                default: begin
                                    unique case (ext_nx)
                                        EXT_WEN:  d.wen = 1'b1;
                                        EXT_WDIS: d.wen = 1'b0;
                                        EXT_FILL: d.state = ST_DATA;
                                        EXT_CLEAR: begin
                                            if (q.wen) begin
                                                d.start = 1'b1;
                                                d.all   = 1'b1;
                                                d.paddr = '0;
                                                d.pdata = '1;
                                            end
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_rise) begin
                        d.dat = dat_nx;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.cnt   = '0;
                            d.state = ST_DONE;
                            if (q.wen) begin
                                d.start = 1'b1;
                                d.all   = (q.hdr[HDR_W-1 -: 2] == OPC_EXT);
                                d.paddr = q.hdr[ADDR_W-1:0];
                                d.pdata = dat_nx;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (sck_rise) begin
                        d.rd_bit = q.rsh[DATA_W-1];
                        d.rd_en  = 1'b1;
                        d.rsh    = {q.rsh[DATA_W-2:0], 1'b0};
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.cnt   = '0;
                            d.state = ST_DONE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    // ST_DONE: wait for chip select to cycle
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign prog_start = q.start;
    assign prog_all   = q.all;
    assign prog_addr  = q.paddr;
    assign prog_data  = q.pdata;
    assign wen_o      = q.wen;
    assign dout_en_o  = q.rd_en | q.st_show;
    assign dout_o     = q.st_show ? ~prog_busy : q.rd_bit;

endmodule

// File: rtl/eep_prog.sv
module eep_prog #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_all,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              wr_en,
    output logic              wr_all,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int TW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0]     cnt;
        logic              all;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } prog_t;

    prog_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == '0) begin
            if (start) begin
                d.cnt  = TW'(PROG_CYCLES);
                d.all  = req_all;
                d.addr = req_addr;
                d.data = req_data;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.cnt != '0);
    assign wr_en   = (q.cnt == TW'(1));
    assign wr_all  = q.all;
    assign wr_addr = q.addr;
    assign wr_data = q.data;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH*DATA_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q, cell_d;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (wr_all || wr_addr == ADDR_W'(g))) cell_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '1;
            else        cell_q <= cell_d;
        end

        assign flat[g*DATA_W +: DATA_W] = cell_q;
    end

    assign rd_data = flat[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic din_i,
    output logic dout_o,
    output logic dout_en_o
);

    logic              cs_s, din_s, sck_rise, cs_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              prog_start, prog_all, prog_busy, wen_st;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic              wr_en, wr_all;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .sck_i    (sck_i),
        .din_i    (din_i),
        .cs_s     (cs_s),
        .din_s    (din_s),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise)
    );

    eep_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .din_s      (din_s),
        .sck_rise   (sck_rise),
        .cs_rise    (cs_rise),
        .prog_busy  (prog_busy),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .prog_start (prog_start),
        .prog_all   (prog_all),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .wen_o      (wen_st),
        .dout_o     (dout_o),
        .dout_en_o  (dout_en_o)
    );

    eep_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (prog_start),
        .req_all  (prog_all),
        .req_addr (prog_addr),
        .req_data (prog_data),
        .busy     (prog_busy),
        .wr_en    (wr_en),
        .wr_all   (wr_all),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int PROG_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic dout_en,
    input logic prog_start,
    input logic prog_busy,
    input logic wen,
    input logic wr_en
);

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_len <= 0;
        else if (prog_busy) busy_len <= busy_len + 1;
        else                busy_len <= 0;
    end

    AST_CS_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_en); // R1

    AST_DRIVE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(cs_s)); // R10

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !prog_busy); // R11

    AST_START_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (busy_len == PROG_CYCLES)); // R9

    AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> prog_busy ##1 !prog_busy); // R9

endmodule

bind tw_eeprom eep_checker #(.PROG_CYCLES(PROG_CYCLES)) u_eep_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .dout_en    (dout_en_o),
    .prog_start (prog_start),
    .prog_busy  (prog_busy),
    .wen        (wen_st),
    .wr_en      (wr_en)
);

// File: tb/tw_eeprom_bench.sv
`timescale 1ns/1ps
module tw_eeprom_bench;

    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, din = 1'b0;
    logic dout, dout_en;
    int   checks = 0, failures = 0;
    bit   finished = 1'b0;
    logic [7:0] bm [128];

    always #2.5 clk = ~clk;

    tw_eeprom #(.PROG_CYCLES(PROG)) u_tw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din),
        .dout_o(dout), .dout_en_o(dout_en)
    );

    // {is_write, addr, data (write value or expected read value)}
    localparam logic [15:0] VEC [10] = '{
        {1'b1, 7'd0,   8'hA5},
        {1'b1, 7'd127, 8'h3C},
        {1'b1, 7'd64,  8'h00},
        {1'b0, 7'd0,   8'hA5},
        {1'b0, 7'd127, 8'h3C},
        {1'b0, 7'd64,  8'h00},
        {1'b1, 7'd0,   8'h7E},
        {1'b0, 7'd0,   8'h7E},
        {1'b0, 7'd1,   8'hFF},
        {1'b0, 7'd2,   8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic so, output logic soe);
        din = b;
        wait_clk(3);
        sck = 1'b1;
        wait_clk(4);
        so  = dout;
        soe = dout_en;
        sck = 1'b0;
        wait_clk(3);
    endtask

    task automatic cs_on();
        cs = 1'b1;
        wait_clk(4);
    endtask

    task automatic cs_off();
        cs = 1'b0;
        din = 1'b0;
        wait_clk(4);
    endtask

    task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] dv,
                         input bit has_d, input bit keep_cs);
        logic so, soe;
        if (!cs) cs_on();
        sbit(1'b1, so, soe);
        for (int i = 1; i >= 0; i--) sbit(op[i], so, soe);
        for (int i = 6; i >= 0; i--) sbit(a[i], so, soe);
        if (has_d) for (int i = 7; i >= 0; i--) sbit(dv[i], so, soe);
        if (!keep_cs) cs_off();
    endtask

    task automatic rd(input logic [6:0] a, input int lead, output logic [7:0] q, output bit en_ok);
        logic so, soe;
        q = '0;
        en_ok = 1'b1;
        cs_on();
        for (int i = 0; i < lead; i++) begin
            sbit(1'b0, so, soe);
            if (soe) en_ok = 1'b0;
        end
        sbit(1'b1, so, soe);
        sbit(1'b1, so, soe);
        sbit(1'b0, so, soe);
        for (int i = 6; i >= 0; i--) begin
            sbit(a[i], so, soe);
            if (soe) en_ok = 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
            sbit(1'b0, so, soe);
            q = {q[6:0], so};
            if (!soe) en_ok = 1'b0;
        end
        cs_off();
    endtask

    task automatic rd_check(input string req, input logic [6:0] a, input int lead);
        logic [7:0] q;
        bit en_ok;
        rd(a, lead, q, en_ok);
        check(req, q, bm[a]);
        check({req, " drive window"}, en_ok, 1'b1);
    endtask

    task automatic prog_wait();
        wait_clk(PROG + 20);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        wait_clk(150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=hung exp=done");
            report();
        end
    end

    initial begin
        logic so, soe;
        for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1: reset state
        check("R1 reset drive", dout_en, 1'b0);
        // R12: erased after reset
        rd_check("R12 reset content", 7'd50, 0);

        // R5: latch clear after reset, write ignored
        issue(2'b01, 7'd5, 8'h12, 1, 0);
        cs_on();
        check("R5 no status when protected", dout_en, 1'b0);
        cs_off();
        prog_wait();
        rd_check("R5 protected write", 7'd5, 0);

        // R5/R10: enable writes, no status after enable
        issue(2'b00, 7'b1100000, 8'h00, 0, 0);
        cs_on();
        check("R10 enable gives no status", dout_en, 1'b0);
        cs_off();

        // R3/R4: table of writes and reads
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][15]) begin
                issue(2'b01, VEC[i][14:8], VEC[i][7:0], 1, 0);
                bm[VEC[i][14:8]] = VEC[i][7:0];
                prog_wait();
            end else begin
                check("R4 model vs table", bm[VEC[i][14:8]], VEC[i][7:0]);
                rd_check("R3 read", VEC[i][14:8], 0);
            end
        end

        // R9: status polling during program cycle
        issue(2'b01, 7'd9, 8'hC3, 1, 0);
        bm[9] = 8'hC3;
        cs_on();
        check("R9 busy drive", dout_en, 1'b1);
        check("R9 busy level", dout, 1'b0);
        wait_clk(PROG);
        check("R9 ready level", dout, 1'b1);
        check("R9 ready drive", dout_en, 1'b1);
        cs_off();
        check("R1 release on cs low", dout_en, 1'b0);
        rd_check("R4 write after poll", 7'd9, 0);

        // R10: chip select low for whole cycle
        issue(2'b01, 7'd10, 8'h99, 1, 0);
        bm[10] = 8'h99;
        prog_wait();
        cs_on();
        check("R10 no status after late raise", dout_en, 1'b0);
        cs_off();
        rd_check("R4 write 10", 7'd10, 0);

        // R11: command during busy ignored
        issue(2'b01, 7'd11, 8'h44, 1, 0);
        bm[11] = 8'h44;
        issue(2'b01, 7'd12, 8'h77, 1, 0);
        prog_wait();
        rd_check("R11 busy command ignored", 7'd12, 0);
        rd_check("R4 write 11", 7'd11, 0);

        // R8: surplus edges after a complete command ignored
        issue(2'b00, 7'b1100000, 8'h00, 0, 1);
        issue(2'b01, 7'd13, 8'h21, 1, 1);
        check("R8 no drive on surplus edges", dout_en, 1'b0);
        cs_off();
        prog_wait();
        rd_check("R8 surplus write ignored", 7'd13, 0);

        // R2: idle clocks with zero before start bit
        rd_check("R2 leading zeros", 7'd0, 5);

        // R1: write aborted in data phase
        cs_on();
        sbit(1'b1, so, soe);
        sbit(1'b0, so, soe);
        sbit(1'b1, so, soe);
        for (int i = 6; i >= 0; i--) sbit(1'b0, so, soe);
        for (int i = 0; i < 4; i++) sbit(1'b1, so, soe);
        cs_off();
        prog_wait();
        rd_check("R1 aborted write", 7'd0, 0);

        // R7: erase all, then fill all
        issue(2'b00, 7'b1000000, 8'h00, 0, 0);
        for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
        prog_wait();
        rd_check("R7 erase all lo", 7'd0, 0);
        rd_check("R7 erase all hi", 7'd127, 0);
        issue(2'b00, 7'b0100000, 8'h5A, 1, 0);
        for (int i = 0; i < 128; i++) bm[i] = 8'h5A;
        prog_wait();
        rd_check("R7 fill lo", 7'd0, 0);
        rd_check("R7 fill mid", 7'd64, 0);
        rd_check("R7 fill hi", 7'd127, 0);

        // R6: byte erase
        issue(2'b11, 7'd3, 8'h00, 0, 0);
        bm[3] = 8'hFF;
        prog_wait();
        rd_check("R6 erased byte", 7'd3, 0);
        rd_check("R6 neighbour kept", 7'd4, 0);

        // R5: disable writes, then write and erase ignored
        issue(2'b00, 7'b0000000, 8'h00, 0, 0);
        issue(2'b01, 7'd4, 8'h00, 1, 0);
        prog_wait();
        rd_check("R5 write after disable", 7'd4, 0);
        issue(2'b11, 7'd4, 8'h00, 0, 0);
        prog_wait();
        rd_check("R5 erase after disable", 7'd4, 0);

        finished = 1'b1;
        report();
    end

endmodule